// File: doc/BRIEF.md
# Multi-Channel Zero-Data Detector

This block watches four audio sample streams and reports, on two flag outputs, when the selected channels have carried only zero data for a long run of frames. Each channel has its own counter of consecutive zero frames, advanced once per frame strobe. A channel counts as silent once its counter has saturated and its present sample is still zero.

Each flag output is the AND of the silent indications of the channels picked by that output's own 4-bit select mask. A polarity control inverts the normal result.

Several controls override the normal result. A detect-enable control and an all-channels-powered-down condition force both flags low. A soft-reset control forces both flags high and clears the counters. When soft reset is lifted, the flags stay high for a fixed number of frames before normal detection resumes. Samples are expected to be held stable across a frame, and a nonzero sample on a selected channel pulls its flag down in the same cycle.

Top module: `zdet_top`

## Requirements
- R1: A channel's counter is cleared to 0 by any frame strobe with a nonzero sample, advances by one on each frame strobe with a zero sample, and saturates at ZERO_RUN. The channel is silent while its counter equals ZERO_RUN and its present sample is zero, so the ZERO_RUN-th consecutive zero frame is the first that makes it silent.
- R2: Output `flag_o[0]` uses `mask_a_i` and `flag_o[1]` uses `mask_b_i`. Bit i of a mask selects channel i, and the normal result is the AND of the silent indications of the selected channels.
- R3: A nonzero sample on any selected channel drives that output's normal result low in the same clock cycle, without waiting for a frame strobe.
- R4: While `run_i` is 0, both flags are 1, whatever the polarity, and every channel counter is held at 0.
- R5: After `run_i` returns to 1, both flags stay 1 until RELEASE_FRAMES frame strobes have occurred. From the cycle after the last of these strobes the normal result is shown.
- R6: While `det_en_i` is 0, both flags are 0, whatever the other controls.
- R7: While `det_en_i` is 1 and all four bits of `pwr_i` are 0, both flags are 0, whatever the polarity and soft reset.
- R8: With `invert_i` at 1, each flag shows the inverse of its normal result. The forced levels of R4 to R7 are not inverted.
- R9: An output whose mask is all zeros has a normal result of 0, so it shows 1 when `invert_i` is 1.
- R10: After asynchronous reset, with enable on, all channels powered, `run_i` at 1 and polarity normal, both flags are 0 until a full zero run has been seen.
- R11: A powered-down channel (its `pwr_i` bit at 0) is still counted: nonzero data on it, if selected, holds the output's normal result low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse per frame period |
| sample_i | input | NCH*DW | Packed samples, channel i in bits [i*DW +: DW] |
| det_en_i | input | 1 | Detect enable, 0 forces flags low |
| invert_i | input | 1 | Polarity invert of the normal result |
| run_i | input | 1 | Soft-reset control, 0 holds the block in reset |
| pwr_i | input | NCH | Per-channel power bits |
| mask_a_i | input | NCH | Channel select for flag_o[0] |
| mask_b_i | input | NCH | Channel select for flag_o[1] |
| flag_o | output | 2 | Zero-detect flags |

## Verification
The bench builds the block with ZERO_RUN=16, RELEASE_FRAMES=4 and DW=8, so saturation, counter clearing and the full release window are each reached in a few dozen frames. This also puts the exact boundary frame of a zero run and the last frame of the release window within reach. The sample width and the channel count stay at values where every select mask and data pattern is cheap to apply. A table drives combinations of mask, data and polarity against saturated counters, and directed steps cover the override levels and their priority.

// File: rtl/zdet_pkg.sv
package zdet_pkg;

  typedef enum logic [1:0] {
    FORCE_NONE = 2'd0,
    FORCE_LOW  = 2'd1,
    FORCE_HIGH = 2'd2
  } force_e;

  function automatic force_e pick_force(input logic en, input logic any_pwr,
                                        input logic run, input logic hold);
    if (!en)               return FORCE_LOW;
    else if (!any_pwr)     return FORCE_LOW;
    else if (!run || hold) return FORCE_HIGH;
    else                   return FORCE_NONE;
  endfunction

endpackage

// File: rtl/zdet_run_counter.sv
module zdet_run_counter #(
  parameter int DW       = 24,
  parameter int ZERO_RUN = 8192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          clr,
  input  logic [DW-1:0] sample,
  output logic          silent_o
);
  localparam int CW = $clog2(ZERO_RUN + 1);
  localparam logic [CW-1:0] SAT = CW'(ZERO_RUN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          is_zero;

  assign is_zero = (sample == '0);
  assign cnt_en  = stb | clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)           cnt_d = '0;
    else if (!is_zero) cnt_d = '0;
    else if (cnt_q != SAT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign silent_o = (cnt_q == SAT) && is_zero;

endmodule

// File: rtl/zdet_release_timer.sv
module zdet_release_timer #(
  parameter int RELEASE_FRAMES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic run,
  output logic hold_o
);
  localparam int RW = (RELEASE_FRAMES > 1) ? $clog2(RELEASE_FRAMES) : 1;
  localparam logic [RW-1:0] LAST = RW'(RELEASE_FRAMES - 1);

  logic [RW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          upd_en;

  assign upd_en = !run || (stb && act_q);

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (!run) begin
      cnt_d = '0;
      act_d = 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
      act_d = 1'b0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign hold_o = act_q;

endmodule

// File: rtl/zdet_flag_merge.sv
module zdet_flag_merge #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] silent,
  input  logic [NCH-1:0] mask,
  output logic           raw_o
);
  assign raw_o = (|mask) && (&(silent | ~mask));
endmodule

// File: rtl/zdet_top.sv
module zdet_top #(
  parameter int NCH            = 4,
  parameter int DW             = 24,
  parameter int ZERO_RUN       = 8192,
  parameter int RELEASE_FRAMES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_stb,
  input  logic [NCH*DW-1:0]   sample_i,
  input  logic                det_en_i,
  input  logic                invert_i,
  input  logic                run_i,
  input  logic [NCH-1:0]      pwr_i,
  input  logic [NCH-1:0]      mask_a_i,
  input  logic [NCH-1:0]      mask_b_i,
  output logic [1:0]          flag_o
);
  import zdet_pkg::*;

  localparam int NOUT = 2;

  logic [NCH-1:0]  silent;
  logic [NOUT-1:0] raw;
  logic            rel_active;
  logic [NCH-1:0]  masks [NOUT];
  force_e          frc;

  assign masks[0] = mask_a_i;
  assign masks[1] = mask_b_i;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    zdet_run_counter #(.DW(DW), .ZERO_RUN(ZERO_RUN)) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (frame_stb),
      .clr      (!run_i),
      .sample   (sample_i[c*DW +: DW]),
      .silent_o (silent[c])
    );
  end

  zdet_release_timer #(.RELEASE_FRAMES(RELEASE_FRAMES)) rel_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (frame_stb),
    .run    (run_i),
    .hold_o (rel_active)
  );

  assign frc = pick_force(det_en_i, |pwr_i, run_i, rel_active);

  for (genvar o = 0; o < NOUT; o++) begin : g_out
    zdet_flag_merge #(.NCH(NCH)) mrg_i (
      .silent (silent),
      .mask   (masks[o]),
      .raw_o  (raw[o])
    );

    always_comb begin
      unique case (frc)
        FORCE_LOW:  flag_o[o] = 1'b0;
        FORCE_HIGH: flag_o[o] = 1'b1;
        default:    flag_o[o] = raw[o] ^ invert_i;
      endcase
    end
  end

endmodule

// File: rtl/zdet_checker.sv
module zdet_checker #(
  parameter int NCH = 4,
  parameter int DW  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH*DW-1:0] sample_i,
  input logic              det_en_i,
  input logic              invert_i,
  input logic              run_i,
  input logic [NCH-1:0]    pwr_i,
  input logic [NCH-1:0]    mask_a_i,
  input logic [NCH-1:0]    mask_b_i,
  input logic [1:0]        flag_o,
  input logic              rel_active
);
  logic [NCH-1:0] nz;
  logic           live;

  for (genvar c = 0; c < NCH; c++) begin : g_nz
    assign nz[c] = |sample_i[c*DW +: DW];
  end

  assign live = det_en_i && (|pwr_i) && run_i && !rel_active;

  AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en_i |-> flag_o == 2'b00); // R6

  AST_PWR_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en_i && pwr_i == '0) |-> flag_o == 2'b00); // R7

  AST_SOFT_RESET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en_i && (|pwr_i) && !run_i) |-> flag_o == 2'b11); // R4

  AST_RELEASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en_i && (|pwr_i) && rel_active) |-> flag_o == 2'b11); // R5

  AST_DROP_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !invert_i && (|(mask_a_i & nz))) |-> !flag_o[0]); // R3

  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (live && mask_b_i == '0) |-> flag_o[1] == invert_i); // R9

endmodule

bind zdet_top zdet_checker #(.NCH(NCH), .DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_i   (sample_i),
  .det_en_i   (det_en_i),
  .invert_i   (invert_i),
  .run_i      (run_i),
  .pwr_i      (pwr_i),
  .mask_a_i   (mask_a_i),
  .mask_b_i   (mask_b_i),
  .flag_o     (flag_o),
  .rel_active (rel_active)
);

// File: tb/zdet_top_tb_top.sv
module zdet_top_tb_top;
  localparam int NCH = 4;
  localparam int DW  = 8;
  localparam int ZR  = 16;
  localparam int RF  = 4;

  typedef struct packed {
    logic [3:0] nz;
    logic [3:0] ma;
    logic [3:0] mb;
    logic       inv;
    logic [1:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'b0000, 4'b1111, 4'b0001, 1'b0, 2'b11},
    '{4'b0001, 4'b1111, 4'b0010, 1'b0, 2'b10},
    '{4'b0100, 4'b0011, 4'b1100, 1'b0, 2'b01},
    '{4'b0000, 4'b0000, 4'b1111, 1'b0, 2'b10},
    '{4'b0000, 4'b0000, 4'b1111, 1'b1, 2'b01},
    '{4'b1000, 4'b0111, 4'b1000, 1'b1, 2'b10},
    '{4'b1111, 4'b1111, 4'b0000, 1'b0, 2'b00},
    '{4'b0110, 4'b1001, 4'b0110, 1'b0, 2'b01}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              frame_stb;
  logic [NCH*DW-1:0] sample_i;
  logic              det_en_i, invert_i, run_i;
  logic [NCH-1:0]    pwr_i, mask_a_i, mask_b_i;
  logic [1:0]        flag_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  zdet_top #(.NCH(NCH), .DW(DW), .ZERO_RUN(ZR), .RELEASE_FRAMES(RF)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .sample_i(sample_i),
    .det_en_i(det_en_i), .invert_i(invert_i), .run_i(run_i), .pwr_i(pwr_i),
    .mask_a_i(mask_a_i), .mask_b_i(mask_b_i), .flag_o(flag_o)
  );

  task automatic check(input string req, input logic [1:0] exp);
    checks++;
    if (flag_o !== exp) begin
      failures++;
      $display("FAIL %s flag_o actual=%b expected=%b", req, flag_o, exp);
    end
  endtask

  task automatic set_nz(input logic [3:0] nz);
    for (int c = 0; c < NCH; c++)
      sample_i[c*DW +: DW] = nz[c] ? 8'(8'h5A + c) : 8'h00;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic strobe(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) frame_stb = 1'b1;
      @(negedge clk) frame_stb = 1'b0;
    end
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_stb = 1'b0; sample_i = '0;
    det_en_i = 1'b1; invert_i = 1'b0; run_i = 1'b1;
    pwr_i = 4'b1111; mask_a_i = 4'b1111; mask_b_i = 4'b1111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check("R10 reset state", 2'b00);

    strobe(ZR - 1);
    check("R1 one frame short of run", 2'b00);
    strobe(1);
    check("R1 run complete", 2'b11);
    strobe(3);
    check("R1 saturated", 2'b11);

    for (int i = 0; i < 8; i++) begin
      set_nz(VECS[i].nz);
      mask_a_i = VECS[i].ma;
      mask_b_i = VECS[i].mb;
      invert_i = VECS[i].inv;
      #1;
      check($sformatf("R2 R3 R8 R9 vector %0d", i), VECS[i].exp);
    end
    set_nz(4'b0000); mask_a_i = 4'b1111; mask_b_i = 4'b1111; invert_i = 1'b0;
    settle();
    check("R1 counters kept without strobe", 2'b11);

    set_nz(4'b0100);
    strobe(1);
    set_nz(4'b0000);
    #1;
    check("R1 cleared by nonzero frame", 2'b00);
    strobe(ZR - 1);
    check("R1 short after clear", 2'b00);
    strobe(1);
    check("R1 recovered", 2'b11);

    pwr_i = 4'b0001;
    set_nz(4'b1000);
    #1;
    check("R11 powered-down channel data", 2'b00);
    set_nz(4'b0000);
    #1;
    check("R11 powered-down channel zero", 2'b11);

    pwr_i = 4'b0000;
    #1;
    check("R7 all powered down", 2'b00);
    invert_i = 1'b1;
    #1;
    check("R7 all powered down inverted", 2'b00);
    pwr_i = 4'b1111;
    #1;
    check("R8 inverted normal", 2'b00);
    invert_i = 1'b0;

    det_en_i = 1'b0;
    #1;
    check("R6 disabled", 2'b00);
    invert_i = 1'b1;
    #1;
    check("R6 disabled inverted", 2'b00);
    invert_i = 1'b0; det_en_i = 1'b1;
    #1;
    check("R6 enabled again", 2'b11);

    run_i = 1'b0;
    #1;
    check("R4 soft reset high", 2'b11);
    invert_i = 1'b1;
    #1;
    check("R4 soft reset inverted", 2'b11);
    invert_i = 1'b0;
    strobe(1);
    check("R4 soft reset with strobe", 2'b11);
    run_i = 1'b1;
    settle();
    check("R5 release starts", 2'b11);
    strobe(RF - 1);
    check("R5 hold before last frame", 2'b11);
    strobe(1);
    check("R5 released, R4 counters cleared", 2'b00);
    strobe(ZR - RF - 1);
    check("R4 counters restarted", 2'b00);
    strobe(1);
    check("R1 run after release", 2'b11);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule